// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the raster timing for a CRT output: horizontal and vertical sync pulses, a display-enable strobe and the current pixel column and line number. It advances one pixel per clock. The host sets the geometry by writing byte registers. Horizontal quantities are given in character cells of eight pixels, and active sizes are written as the count minus one. A sync start and the blanking length that goes with it sit in adjacent bytes, so a single 16-bit write sets both.

The host can read back every writable register. It can also read a flag that shows whether the raster is in the vertical blanking interval, and the line the raster is currently on. A display-control byte carries a pixel-depth code and a blank bit. These go straight out to the pixel path. A separate output-select byte turns the raster on or off.

While the raster runs, timing writes are buffered and take effect at the next frame boundary, so a frame is never built from mixed geometry. While the output is deselected, the counters sit at the origin and the timing registers are taken over on every clock. The next enable therefore starts a clean frame with the newest values.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset the output select is 0, so the display is off. de is low, both syncs sit at their inactive high level and pix_x and pix_y are 0. The registers read back their defaults: 0x0=79, 0x2=23, 0x3=2, 0x4=0x04, 0x6=0xDF, 0x7=0x01, 0x8 bits 6:0=39, 0x9=8, 0xA=0x02, 0xE=0x05, 0xF=0x00.
- R2: A write stores wr_data[7:0] at wr_addr when wr_be[0] is set. It stores wr_data[15:8] at wr_addr+1 (modulo 16) when wr_be[1] is set. Both lanes are written in the same clock. The register map is:
  - 0x0: active width in cells minus one.
  - 0x2: horizontal blank in cells minus one.
  - 0x3: hsync start in cells.
  - 0x4: bit 7 hsync polarity, bits 6:0 hsync width in cells.
  - 0x6 and 0x7: active lines minus one, low 8 bits and high 2 bits.
  - 0x8: bits 6:0 vertical blank lines minus one.
  - 0x9: vsync start in lines.
  - 0xA: bit 7 vsync polarity, bits 6:0 vsync width in lines.
  - 0xE: bit 7 blank, bits 2:0 depth.
  - 0xF: output select.
  Writes to 0x1, 0x5, 0xB, 0xC and 0xD, and to bit 7 of 0x8, are ignored. Unimplemented bits read as 0.
- R3: A line lasts (reg0x0 + 1 + reg0x2 + 1) × 8 clocks. pix_x counts up from 0 by one each clock and wraps to 0 at the end of the line.
- R4: A frame lasts (active lines + reg0x8 + 1) lines. pix_y rises by one when pix_x wraps and returns to 0 after the last line. pix_y never changes in the middle of a line.
- R5: hsync is asserted for pix_x in [A + 8·S, A + 8·S + 8·W), where A = (reg0x0 + 1) × 8, S = reg0x3 and W = reg0x4 bits 6:0. The asserted level is reg0x4 bit 7 and the inactive level is its inverse. A width of 0 gives no pulse.
- R6: vsync is asserted for pix_y in [L + S, L + S + W), where L is the active line count, S = reg0x9 and W = reg0xA bits 6:0. The polarity comes from reg0xA bit 7 in the same way as for hsync.
- R7: de is high exactly when pix_x < A, pix_y < L, the output select equals 2 and the blank bit (reg0xE bit 7) is clear.
- R8: Output select 2 enables the raster. Any other value (0, 3, ...) holds pix_x and pix_y at 0, keeps de low, keeps both syncs at their inactive levels and copies the timing registers into use on every clock.
- R9: While the raster runs, a timing write changes no output until the clock in which the raster wraps to line 0, column 0. From that clock the whole frame follows the new values.
- R10: Reading 0x8 gives bit 7 set while pix_y ≥ L, with bits 6:0 holding the stored blank value. Reading 0xC gives the current line bits 7:0 and 0xD gives bits 10:8.
- R11: px_depth follows reg0xE bits 2:0 and px_blank follows bit 7, one clock after the write and without waiting for a frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte address of the low write lane |
| wr_be | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data, low lane in bits 7:0 |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Read data, combinational |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| pix_x | output | 12 | Current pixel column |
| pix_y | output | 11 | Current line |
| px_depth | output | 3 | Pixel depth code for the pixel path |
| px_blank | output | 1 | Blank flag for the pixel path |

## Verification
The bench rewrites the blanking length, sync offsets and polarity halfway through a frame. A design that applied them at once would produce a short line or a sync pulse out of place before the wrap. The bench also drives sync windows that are zero wide or that run past the end of the line. Either one exposes an off-by-one in the cell-to-pixel scaling or a pulse that wraps into the next line. It writes one byte lane at a time, writes to the read-only line counter, and uses an output-select value that is neither 0 nor 2; a decoder that is too loose would corrupt stored geometry or start the raster. The read address cycles on every clock, so the line counter and the vertical blanking flag are compared on every line against an independent frame model.

// File: rtl/crt_pkg.sv
package crt_pkg;
  parameter int CHAR_LG = 3;
  parameter int HREG_W  = 8;
  parameter int VACT_W  = 10;
  parameter int VBL_W   = 7;
  parameter int PW_W    = 7;
  parameter int ADDR_W  = 4;
  parameter int LANES   = 2;
  parameter int DEPTH_W = 3;

  localparam int HC_W = HREG_W + 1 + CHAR_LG;
  localparam int VC_W = VACT_W + 1;
  localparam int HX_W = HC_W + 2;
  localparam int VX_W = VC_W + 2;

  typedef struct packed {
    logic [HREG_W-1:0] hact_m1;
    logic [HREG_W-1:0] hbl_m1;
    logic [HREG_W-1:0] hss;
    logic              hpol;
    logic [PW_W-1:0]   hsw;
    logic [VACT_W-1:0] vact_m1;
    logic [VBL_W-1:0]  vbl_m1;
    logic [HREG_W-1:0] vss;
    logic              vpol;
    logic [PW_W-1:0]   vsw;
  } crt_timing_t;

  localparam crt_timing_t TIMING_RST = '{
    hact_m1: HREG_W'(79),
    hbl_m1:  HREG_W'(23),
    hss:     HREG_W'(2),
    hpol:    1'b0,
    hsw:     PW_W'(4),
    vact_m1: VACT_W'(479),
    vbl_m1:  VBL_W'(39),
    vss:     HREG_W'(8),
    vpol:    1'b0,
    vsw:     PW_W'(2)
  };

  localparam logic [DEPTH_W-1:0] DEPTH_RST = DEPTH_W'(5);

  localparam logic [ADDR_W-1:0] A_HACT   = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_HBL    = ADDR_W'(4'h2);
  localparam logic [ADDR_W-1:0] A_HSS    = ADDR_W'(4'h3);
  localparam logic [ADDR_W-1:0] A_HSW    = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_VACT_L = ADDR_W'(4'h6);
  localparam logic [ADDR_W-1:0] A_VACT_H = ADDR_W'(4'h7);
  localparam logic [ADDR_W-1:0] A_VBL    = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] A_VSS    = ADDR_W'(4'h9);
  localparam logic [ADDR_W-1:0] A_VSW    = ADDR_W'(4'hA);
  localparam logic [ADDR_W-1:0] A_LINE_L = ADDR_W'(4'hC);
  localparam logic [ADDR_W-1:0] A_LINE_H = ADDR_W'(4'hD);
  localparam logic [ADDR_W-1:0] A_DISP   = ADDR_W'(4'hE);
  localparam logic [ADDR_W-1:0] A_OSEL   = ADDR_W'(4'hF);

  localparam logic [7:0] OSEL_CRT = 8'd2;

  // cells-minus-one to pixel count
  function automatic logic [HX_W-1:0] cells_to_px(input logic [HREG_W-1:0] cm1);
    return (HX_W'(cm1) + HX_W'(1)) << CHAR_LG;
  endfunction
endpackage

// File: rtl/crt_rst_sync.sv
module crt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_s = sh_q[1];
endmodule

// File: rtl/crt_regs.sv
module crt_regs
  import crt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LANES-1:0]   wr_be,
  input  logic [LANES*8-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [VC_W-1:0]    line_cnt,
  input  logic               vbl_flag,
  output logic [7:0]         rd_data,
  output crt_timing_t        pend,
  output logic [DEPTH_W-1:0] depth,
  output logic               blank,
  output logic               crt_on
);
  crt_timing_t        pend_q, pend_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               blank_q, blank_d;
  logic [7:0]         osel_q, osel_d;

  logic [ADDR_W-1:0]  lane_addr [LANES];
  logic [7:0]         lane_byte [LANES];
  logic [LANES-1:0]   lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = wr_addr + ADDR_W'(g);
    assign lane_byte[g] = wr_data[g*8 +: 8];
    assign lane_we[g]   = wr_en & wr_be[g];
  end

  always_comb begin
    pend_d  = pend_q;
    depth_d = depth_q;
    blank_d = blank_q;
    osel_d  = osel_q;
    for (int ln = 0; ln < LANES; ln++) begin
      if (lane_we[ln]) begin
        case (lane_addr[ln])
          A_HACT:   pend_d.hact_m1 = lane_byte[ln];
          A_HBL:    pend_d.hbl_m1  = lane_byte[ln];
          A_HSS:    pend_d.hss     = lane_byte[ln];
          A_HSW:    {pend_d.hpol, pend_d.hsw} = lane_byte[ln];
          A_VACT_L: pend_d.vact_m1[7:0] = lane_byte[ln];
          A_VACT_H: pend_d.vact_m1[VACT_W-1:8] = lane_byte[ln][VACT_W-9:0];
          A_VBL:    pend_d.vbl_m1  = lane_byte[ln][VBL_W-1:0];
          A_VSS:    pend_d.vss     = lane_byte[ln];
          A_VSW:    {pend_d.vpol, pend_d.vsw} = lane_byte[ln];
          A_DISP: begin
            blank_d = lane_byte[ln][7];
            depth_d = lane_byte[ln][DEPTH_W-1:0];
          end
          A_OSEL:   osel_d = lane_byte[ln];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= TIMING_RST;
      depth_q <= DEPTH_RST;
      blank_q <= 1'b0;
      osel_q  <= 8'd0;
    end else if (wr_en) begin
      pend_q  <= pend_d;
      depth_q <= depth_d;
      blank_q <= blank_d;
      osel_q  <= osel_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_HACT:   rd_data = pend_q.hact_m1;
      A_HBL:    rd_data = pend_q.hbl_m1;
      A_HSS:    rd_data = pend_q.hss;
      A_HSW:    rd_data = {pend_q.hpol, pend_q.hsw};
      A_VACT_L: rd_data = pend_q.vact_m1[7:0];
      A_VACT_H: rd_data = 8'(pend_q.vact_m1[VACT_W-1:8]);
      A_VBL:    rd_data = {vbl_flag, pend_q.vbl_m1};
      A_VSS:    rd_data = pend_q.vss;
      A_VSW:    rd_data = {pend_q.vpol, pend_q.vsw};
      A_LINE_L: rd_data = line_cnt[7:0];
      A_LINE_H: rd_data = 8'(line_cnt[VC_W-1:8]);
      A_DISP:   rd_data = {blank_q, (7-DEPTH_W)'(0), depth_q};
      A_OSEL:   rd_data = osel_q;
      default:  rd_data = 8'd0;
    endcase
  end

  assign pend   = pend_q;
  assign depth  = depth_q;
  assign blank  = blank_q;
  assign crt_on = (osel_q == OSEL_CRT);
endmodule

// File: rtl/crt_scan.sv
module crt_scan
  import crt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            crt_on,
  input  crt_timing_t     pend,
  output crt_timing_t     live,
  output logic [HC_W-1:0] hc,
  output logic [VC_W-1:0] vc,
  output logic            vbl_flag
);
  crt_timing_t     live_q;
  logic [HC_W-1:0] hc_q, hc_d;
  logic [VC_W-1:0] vc_q, vc_d;
  logic [HX_W-1:0] htot;
  logic [VX_W-1:0] vact_n, vtot;
  logic            h_last, v_last, live_ld;

  assign htot   = cells_to_px(live_q.hact_m1) + cells_to_px(live_q.hbl_m1);
  assign vact_n = VX_W'(live_q.vact_m1) + VX_W'(1);
  assign vtot   = vact_n + VX_W'(live_q.vbl_m1) + VX_W'(1);
  assign h_last = (HX_W'(hc_q) == htot - HX_W'(1));
  assign v_last = (VX_W'(vc_q) == vtot - VX_W'(1));

  always_comb begin
    hc_d    = hc_q;
    vc_d    = vc_q;
    live_ld = 1'b0;
    if (!crt_on) begin
      hc_d    = '0;
      vc_d    = '0;
      live_ld = 1'b1;
    end else if (h_last) begin
      hc_d = '0;
      if (v_last) begin
        vc_d    = '0;
        live_ld = 1'b1;
      end else begin
        vc_d = vc_q + VC_W'(1);
      end
    end else begin
      hc_d = hc_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= '0;
      vc_q <= '0;
    end else begin
      hc_q <= hc_d;
      vc_q <= vc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= TIMING_RST;
    else if (live_ld) live_q <= pend;
  end

  assign live     = live_q;
  assign hc       = hc_q;
  assign vc       = vc_q;
  assign vbl_flag = (VX_W'(vc_q) >= vact_n);
endmodule

// File: rtl/crt_sync_out.sv
module crt_sync_out
  import crt_pkg::*;
(
  input  logic [HREG_W-1:0] hact_m1,
  input  logic [HREG_W-1:0] hss,
  input  logic              hpol,
  input  logic [PW_W-1:0]   hsw,
  input  logic [VACT_W-1:0] vact_m1,
  input  logic [HREG_W-1:0] vss,
  input  logic              vpol,
  input  logic [PW_W-1:0]   vsw,
  input  logic [HC_W-1:0]   hc,
  input  logic [VC_W-1:0]   vc,
  input  logic              crt_on,
  input  logic              blank,
  output logic              hsync,
  output logic              vsync,
  output logic              de
);
  logic [HX_W-1:0] hact_px, hs_beg, hs_end, hcx;
  logic [VX_W-1:0] vact_n, vs_beg, vs_end, vcx;
  logic            h_in, v_in;

  assign hcx     = HX_W'(hc);
  assign vcx     = VX_W'(vc);
  assign hact_px = cells_to_px(hact_m1);
  assign hs_beg  = hact_px + (HX_W'(hss) << CHAR_LG);
  assign hs_end  = hs_beg + (HX_W'(hsw) << CHAR_LG);
  assign vact_n  = VX_W'(vact_m1) + VX_W'(1);
  assign vs_beg  = vact_n + VX_W'(vss);
  assign vs_end  = vs_beg + VX_W'(vsw);

  assign h_in = crt_on && (hcx >= hs_beg) && (hcx < hs_end);
  assign v_in = crt_on && (vcx >= vs_beg) && (vcx < vs_end);

  assign hsync = h_in ? hpol : ~hpol;
  assign vsync = v_in ? vpol : ~vpol;
  assign de    = crt_on && !blank && (hcx < hact_px) && (vcx < vact_n);
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LANES-1:0]   wr_be,
  input  logic [LANES*8-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [HC_W-1:0]    pix_x,
  output logic [VC_W-1:0]    pix_y,
  output logic [DEPTH_W-1:0] px_depth,
  output logic               px_blank
);
  logic        rst_s;
  crt_timing_t pend, live;
  logic        crt_on, vbl_flag;
  logic [HC_W-1:0] hc;
  logic [VC_W-1:0] vc;

  crt_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  crt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .line_cnt (vc),
    .vbl_flag (vbl_flag),
    .rd_data  (rd_data),
    .pend     (pend),
    .depth    (px_depth),
    .blank    (px_blank),
    .crt_on   (crt_on)
  );

  crt_scan u_scan (
    .clk      (clk),
    .rst_n    (rst_s),
    .crt_on   (crt_on),
    .pend     (pend),
    .live     (live),
    .hc       (hc),
    .vc       (vc),
    .vbl_flag (vbl_flag)
  );

  crt_sync_out u_sync (
    .hact_m1 (live.hact_m1),
    .hss     (live.hss),
    .hpol    (live.hpol),
    .hsw     (live.hsw),
    .vact_m1 (live.vact_m1),
    .vss     (live.vss),
    .vpol    (live.vpol),
    .vsw     (live.vsw),
    .hc      (hc),
    .vc      (vc),
    .crt_on  (crt_on),
    .blank   (px_blank),
    .hsync   (hsync),
    .vsync   (vsync),
    .de      (de)
  );

  assign pix_x = hc;
  assign pix_y = vc;
endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk
  import crt_pkg::*;
(
  input logic            clk,
  input logic            rst_s,
  input logic            de,
  input logic            crt_on,
  input logic            vbl_flag,
  input logic [HC_W-1:0] pix_x,
  input logic [VC_W-1:0] pix_y,
  input crt_timing_t     live
);
  AST_OFF_NO_DE: assert property (@(posedge clk) disable iff (!rst_s)
    !crt_on |-> !de); // R8

  AST_OFF_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_s)
    !crt_on |=> (pix_x == '0 && pix_y == '0)); // R8

  AST_X_STEPS: assert property (@(posedge clk) disable iff (!rst_s)
    (pix_x != '0) |-> (pix_x == $past(pix_x) + HC_W'(1))); // R3

  AST_Y_HOLDS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_s)
    (pix_x != '0) |-> $stable(pix_y)); // R4

  AST_DE_NOT_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_s)
    de |-> !vbl_flag); // R10

  AST_LIVE_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_s)
    (pix_x != '0 || pix_y != '0) |-> $stable(live)); // R9
endmodule

bind crt_timing_gen crt_timing_chk u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .de       (de),
  .crt_on   (crt_on),
  .vbl_flag (vbl_flag),
  .pix_x    (pix_x),
  .pix_y    (pix_y),
  .live     (live)
);

// File: tb/sim_crt_timing_gen.sv
`timescale 1ns/1ps
module sim_crt_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = 4'd0;
  logic [1:0]  wr_be = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [3:0]  rd_addr = 4'd0;
  logic [7:0]  rd_data;
  logic        hsync, vsync, de, px_blank;
  logic [11:0] pix_x;
  logic [10:0] pix_y;
  logic [2:0]  px_depth;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // behavioural model state
  int p_hact, p_hbl, p_hss, p_hpol, p_hsw, p_vact, p_vbl, p_vss, p_vpol, p_vsw;
  int l_hact, l_hbl, l_hss, l_hpol, l_hsw, l_vact, l_vbl, l_vss, l_vpol, l_vsw;
  int m_hc, m_vc, m_depth, m_blank, m_osel;
  bit m_r1, m_r2;

  always #5 clk = ~clk;

  crt_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .px_depth(px_depth),
    .px_blank(px_blank)
  );

  task automatic m_load();
    l_hact = p_hact; l_hbl = p_hbl; l_hss = p_hss; l_hpol = p_hpol; l_hsw = p_hsw;
    l_vact = p_vact; l_vbl = p_vbl; l_vss = p_vss; l_vpol = p_vpol; l_vsw = p_vsw;
  endtask

  task automatic m_reset();
    p_hact = 79; p_hbl = 23; p_hss = 2; p_hpol = 0; p_hsw = 4;
    p_vact = 479; p_vbl = 39; p_vss = 8; p_vpol = 0; p_vsw = 2;
    m_load();
    m_hc = 0; m_vc = 0; m_depth = 5; m_blank = 0; m_osel = 0;
  endtask

  task automatic m_wbyte(input int a, input int b);
    case (a)
      0:  p_hact = b;
      2:  p_hbl = b;
      3:  p_hss = b;
      4:  begin p_hpol = (b >> 7) & 1; p_hsw = b & 127; end
      6:  p_vact = (p_vact & 'h300) | b;
      7:  p_vact = (p_vact & 255) | ((b & 3) << 8);
      8:  p_vbl = b & 127;
      9:  p_vss = b;
      10: begin p_vpol = (b >> 7) & 1; p_vsw = b & 127; end
      14: begin m_blank = (b >> 7) & 1; m_depth = b & 7; end
      15: m_osel = b;
      default: ;
    endcase
  endtask

  function automatic int m_read(input int a);
    case (a)
      0:  return p_hact;
      2:  return p_hbl;
      3:  return p_hss;
      4:  return (p_hpol << 7) | p_hsw;
      6:  return p_vact & 255;
      7:  return p_vact >> 8;
      8:  return ((m_vc >= l_vact + 1) ? 128 : 0) | p_vbl;
      9:  return p_vss;
      10: return (p_vpol << 7) | p_vsw;
      12: return m_vc & 255;
      13: return m_vc >> 8;
      14: return (m_blank << 7) | m_depth;
      15: return m_osel;
      default: return 0;
    endcase
  endfunction

  always @(negedge rst_n) begin
    m_r1 = 0; m_r2 = 0;
    m_reset();
  end

  always @(posedge clk) begin
    int ht, vt;
    bit run;
    run = m_r2;
    m_r2 = m_r1;
    m_r1 = rst_n;
    if (!run) begin
      m_reset();
    end else begin
      ht = (l_hact + l_hbl + 2) * 8;
      vt = l_vact + l_vbl + 2;
      if (m_osel != 2) begin
        m_hc = 0; m_vc = 0; m_load();
      end else if (m_hc == ht - 1) begin
        m_hc = 0;
        if (m_vc == vt - 1) begin m_vc = 0; m_load(); end
        else m_vc++;
      end else begin
        m_hc++;
      end
      if (wr_en)
        for (int ln = 0; ln < 2; ln++)
          if (wr_be[ln]) m_wbyte((int'(wr_addr) + ln) % 16, int'(wr_data[ln*8 +: 8]));
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int hpx, hsb, hse, vn, vsb, vse, ehs, evs, ede;
    bit on, inr;
    if (!done) begin
      inr = !m_r2;
      on  = (m_osel == 2);
      hpx = (l_hact + 1) * 8;
      hsb = hpx + l_hss * 8;
      hse = hsb + l_hsw * 8;
      vn  = l_vact + 1;
      vsb = vn + l_vss;
      vse = vsb + l_vsw;
      ede = (on && !m_blank && m_hc < hpx && m_vc < vn) ? 1 : 0;
      ehs = (on && m_hc >= hsb && m_hc < hse) ? l_hpol : 1 - l_hpol;
      evs = (on && m_vc >= vsb && m_vc < vse) ? l_vpol : 1 - l_vpol;
      chk(inr ? "R1" : "R7/R8", int'(de), ede);
      chk(inr ? "R1" : "R5/R8", int'(hsync), ehs);
      chk(inr ? "R1" : "R6/R8", int'(vsync), evs);
      chk(inr ? "R1" : "R3/R9", int'(pix_x), m_hc);
      chk(inr ? "R1" : "R4/R9", int'(pix_y), m_vc);
      chk(inr ? "R1" : "R11", int'(px_depth), m_depth);
      chk(inr ? "R1" : "R11", int'(px_blank), m_blank);
      if (inr) chk("R1", int'(rd_data), m_read(int'(rd_addr)));
      else if (rd_addr == 4'h8 || rd_addr == 4'hC || rd_addr == 4'hD)
        chk("R10", int'(rd_data), m_read(int'(rd_addr)));
      else chk("R2", int'(rd_data), m_read(int'(rd_addr)));
      rd_addr = rd_addr + 4'd1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    m_reset();
    #2 rst_n = 1'b0;
    idle(20);                           // R1 defaults read back under reset
    rst_n = 1'b1;
    idle(20);
    // R2: small geometry while off (R8 loads it directly)
    wr(4'h0, 2'b11, 16'h0001);          // active 2 cells
    wr(4'h2, 2'b11, 16'h0000);          // blank 1 cell, hsync start 0
    wr(4'h4, 2'b01, 16'hFF01);          // hsync 1 cell, active low; high lane off
    wr(4'h6, 2'b11, 16'h0003);          // 4 active lines
    wr(4'h8, 2'b11, 16'h0081);          // blank 2 lines, vsync start 0, bit7 ignored
    wr(4'hA, 2'b01, 16'h0081);          // vsync 1 line, active high
    wr(4'hE, 2'b11, 16'h0203);          // depth 3, raster on (R11, R8)
    idle(450);
    // R9: mid-frame change of blank, sync start, width and polarity
    idle(37);
    wr(4'h2, 2'b11, 16'h0102);
    wr(4'h4, 2'b11, 16'h0082);
    idle(500);
    // R5: sync running past the end of the line
    wr(4'h3, 2'b01, 16'h0002);
    wr(4'h4, 2'b01, 16'h0005);
    idle(500);
    // R6: vsync offset, zero width, then past frame end
    wr(4'h9, 2'b11, 16'h0001);
    idle(300);
    wr(4'h9, 2'b11, 16'h0302);
    idle(400);
    // R11 / R7: blank and depth, one lane
    wr(4'hE, 2'b01, 16'hAA85);
    idle(120);
    wr(4'hE, 2'b01, 16'h0004);
    // R2: ignored addresses and read-only counter
    wr(4'hC, 2'b11, 16'hFFFF);
    wr(4'h1, 2'b01, 16'h00FF);
    wr(4'hB, 2'b01, 16'h00FF);
    idle(100);
    // R4 / R10: long active height through the high lane only
    wr(4'h6, 2'b10, 16'h01AA);
    idle(12000);
    wr(4'h6, 2'b10, 16'h0000);
    idle(11000);
    // R8: odd select value and off, changes while off
    wr(4'hF, 2'b01, 16'h0003);
    idle(60);
    wr(4'h0, 2'b11, 16'h0002);
    wr(4'h4, 2'b01, 16'h0001);
    idle(30);
    wr(4'hE, 2'b10, 16'h0200);
    idle(800);
    wr(4'hF, 2'b01, 16'h0000);
    idle(40);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule